// File: doc/BRIEF.md
# PWM Prescaler and Period-Divider Pair Search

This unit takes a requested PWM period, given as a count of input clock cycles, and picks two 16-bit divider codes whose product approximates that count. The codes are a prescaler `p` and a period divider `d`, and the period they produce is `(p+1)*(d+1)` cycles. A driver or configuration sequencer hands the unit one target. It then waits for the done pulse, reads the chosen pair and the leftover error, and programs them into a PWM channel.

The unit tries one prescaler candidate at a time. For each candidate, a restoring shift-subtract divider works out `target / (p+1)`. The unit keeps the best candidate seen so far and stops under any of these conditions:
- the prescaler would exceed the period divider, which only mirrors pairs already tried;
- the quotient underflows;
- an exact fit is found;
- the prescaler reaches its top code.

The top period-divider code is never chosen, so that a duty count one above the divider (100 % duty) remains expressible.

The request side is a valid/ready handshake. `req_ready` is high only while the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a search runs, `req_ready` stays low and `req_valid` is ignored, so the requester holds its target until it is accepted. The result side has no back-pressure. `done` pulses for one cycle, and the result ports keep their values until the next request is accepted.

Top module: `pwm_divpair_search`

## Requirements
- R1: `req_ready` is high while idle and low from the cycle after an accepted request until the cycle in which `done` is high. A `req_valid` raised while `req_ready` is low has no effect on the search or its result.
- R2: The first prescaler candidate is `floor(target / 65536)`, and candidates then rise by one.
- R3: For prescaler candidate `p`, the period divider is `floor(target/(p+1)) - 1` and the candidate's error is `target mod (p+1)`. A chosen pair reports exactly these values on `res_pre`, `res_div` and `res_err`.
- R4: The search ends without taking the candidate when `floor(target/(p+1))` is 0, or when `p` is greater than that candidate's period divider.
- R5: A candidate whose period divider exceeds 0xFFFE is never chosen.
- R6: A candidate replaces the best pair only when its error is strictly smaller than the best error so far. The best error starts equal to the target.
- R7: A candidate with error 0 ends the search at once. Each candidate costs at most TGT_W+4 clock cycles from acceptance to `done`.
- R8: If no candidate is taken, the result is `res_pre` = 0xFFFF, `res_div` = 0xFFFF and `res_err` = target.
- R9: The prescaler candidate never exceeds 0xFFFF, and the search ends after the 0xFFFF candidate is evaluated.
- R10: `done` is high for exactly one cycle per accepted request. `res_pre`, `res_div` and `res_err` hold their values from that cycle until the next accepted request.
- R11: After reset, `req_ready` = 1, `done` = 0, `res_pre` = 0xFFFF, `res_div` = 0xFFFF and `res_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Target request valid |
| req_ready | output | 1 | Unit idle; request taken on valid and ready |
| req_target | input | TGT_W | Requested period in input clock cycles |
| done | output | 1 | One-cycle pulse: result ports are final |
| res_pre | output | DIV_W | Chosen prescaler code |
| res_div | output | DIV_W | Chosen period-divider code |
| res_err | output | TGT_W | Remainder of the chosen pair (target if none) |

## Verification
A corrupted best-so-far register shows up on the result ports in the `done` cycle. Symptoms are a pair with a larger error than the ideal one, a later pair that has the same error as an earlier one, or a default 0xFFFF pair returned for a target that has a fit. A faulty stop rule changes either the returned pair or the latency. A missing exact-fit exit stretches a two-candidate search to hundreds of candidates, so the per-candidate cycle bound catches it on the first such target. Candidate-start errors and mirrored-pair errors show up in a single request, for targets chosen so that the first candidate is either an exact fit or already past the mirror point.

// File: rtl/pwm_search_pkg.sv
package pwm_search_pkg;

  typedef enum logic [1:0] {
    SRCH_IDLE = 2'd0,
    SRCH_KICK = 2'd1,
    SRCH_WAIT = 2'd2
  } srch_state_e;

endpackage

// File: rtl/seq_divider.sv
// Restoring shift-subtract divider, one quotient bit per clock.
module seq_divider #(
  parameter int NW = 32,
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [NW-1:0] quotient,
  output logic [DW-1:0] remainder,
  output logic          done
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] quo_q;
  logic [DW-1:0] rem_q;
  logic [DW-1:0] dvs_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   shifted;
  logic [DW-1:0] diff;
  logic          ge;

  always_comb begin
    shifted = {rem_q, quo_q[NW-1]};
    ge      = shifted >= {1'b0, dvs_q};
    diff    = shifted[DW-1:0] - dvs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (start) begin
      quo_q <= dividend;
      rem_q <= '0;
      dvs_q <= divisor;
      cnt_q <= CW'(NW);
      done  <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q <= ge ? diff : shifted[DW-1:0];
      quo_q <= {quo_q[NW-2:0], ge};
      cnt_q <= cnt_q - 1'b1;
      done  <= (cnt_q == CW'(1));
    end else begin
      done  <= 1'b0;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/best_pair_reg.sv
// Best-so-far store: replaces only on a strictly smaller error.
module best_pair_reg #(
  parameter int DIV_W  = 16,
  parameter int ERR_W  = 32,
  parameter int CAND_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ERR_W-1:0]  init_err,
  input  logic              offer,
  input  logic [DIV_W-1:0]  cand_pre,
  input  logic [DIV_W-1:0]  cand_div,
  input  logic [CAND_W-1:0] cand_err,
  output logic [DIV_W-1:0]  best_pre,
  output logic [DIV_W-1:0]  best_div,
  output logic [ERR_W-1:0]  best_err
);
  logic better;
  assign better = ERR_W'(cand_err) < best_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_pre <= '1;
      best_div <= '1;
      best_err <= '0;
    end else if (init) begin
      best_pre <= '1;
      best_div <= '1;
      best_err <= init_err;
    end else if (offer && better) begin
      best_pre <= cand_pre;
      best_div <= cand_div;
      best_err <= ERR_W'(cand_err);
    end
  end
endmodule

// File: rtl/pwm_divpair_search.sv
module pwm_divpair_search
  import pwm_search_pkg::*;
#(
  parameter int TGT_W = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TGT_W-1:0] req_target,
  output logic             done,
  output logic [DIV_W-1:0] res_pre,
  output logic [DIV_W-1:0] res_div,
  output logic [TGT_W-1:0] res_err
);
  localparam int               DVS_W     = DIV_W + 1;
  localparam logic [DIV_W-1:0] CODE_TOP  = '1;
  localparam logic [TGT_W-1:0] DIV_LIMIT = TGT_W'((64'd1 << DIV_W) - 64'd2);

  srch_state_e      st_q;
  logic [TGT_W-1:0] tgt_q;
  logic [DIV_W-1:0] pre_q;
  logic             done_q;

  logic             accept;
  logic [TGT_W-1:0] tgt_hi;
  logic [DIV_W-1:0] pre_first;
  logic [DVS_W-1:0] dvs;
  logic [TGT_W-1:0] dv_quo;
  logic [DVS_W-1:0] dv_rem;
  logic             dv_done;
  logic             eval;
  logic [TGT_W-1:0] cand_div;
  logic             stop_now, fits, offer, exact, last;

  assign req_ready = (st_q == SRCH_IDLE);
  assign accept    = req_valid && req_ready;
  assign done      = done_q;

  // first candidate: smaller prescalers cannot fit any better
  always_comb begin
    tgt_hi    = req_target >> DIV_W;
    pre_first = (tgt_hi > TGT_W'(CODE_TOP)) ? CODE_TOP : tgt_hi[DIV_W-1:0];
  end

  assign dvs = {1'b0, pre_q} + DVS_W'(1);

  seq_divider #(.NW(TGT_W), .DW(DVS_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (st_q == SRCH_KICK),
    .dividend  (tgt_q),
    .divisor   (dvs),
    .quotient  (dv_quo),
    .remainder (dv_rem),
    .done      (dv_done)
  );

  // candidate evaluation in the cycle the quotient is ready
  always_comb begin
    eval     = (st_q == SRCH_WAIT) && dv_done;
    cand_div = dv_quo - TGT_W'(1);
    stop_now = (dv_quo == '0) || (TGT_W'(pre_q) > cand_div);
    fits     = cand_div <= DIV_LIMIT;
    offer    = eval && !stop_now && fits;
    exact    = offer && (dv_rem == '0);
    last     = stop_now || exact || (pre_q == CODE_TOP);
  end

  best_pair_reg #(.DIV_W(DIV_W), .ERR_W(TGT_W), .CAND_W(DVS_W)) u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (accept),
    .init_err (req_target),
    .offer    (offer),
    .cand_pre (pre_q),
    .cand_div (cand_div[DIV_W-1:0]),
    .cand_err (dv_rem),
    .best_pre (res_pre),
    .best_div (res_div),
    .best_err (res_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SRCH_IDLE;
      tgt_q  <= '0;
      pre_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SRCH_IDLE: if (accept) begin
          tgt_q <= req_target;
          pre_q <= pre_first;
          st_q  <= SRCH_KICK;
        end
        SRCH_KICK: st_q <= SRCH_WAIT;
        SRCH_WAIT: if (eval) begin
          if (last) begin
            st_q   <= SRCH_IDLE;
            done_q <= 1'b1;
          end else begin
            pre_q <= pre_q + 1'b1;
            st_q  <= SRCH_KICK;
          end
        end
        default: st_q <= SRCH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwm_divpair_search_chk.sv
module pwm_divpair_search_chk #(
  parameter int TGT_W = 32,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic [DIV_W-1:0] res_pre,
  input logic [DIV_W-1:0] res_div,
  input logic [TGT_W-1:0] res_err
);
  localparam logic [DIV_W-1:0] TOP = '1;

  // R1: an accepted request closes the handshake on the next cycle
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1: the result pulse coincides with the unit being idle again
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: idle without a new request keeps the result
  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=>
      ($stable(res_pre) && $stable(res_div) && $stable(res_err)));

  // R5: a chosen divider is below the top code
  p_reserve_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_pre != TOP) |-> (res_div < TOP));

  // R4: a chosen pair lies in the prescaler <= divider half
  p_pair_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_div != TOP) |-> (res_pre <= res_div));
endmodule

bind pwm_divpair_search pwm_divpair_search_chk #(.TGT_W(TGT_W), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .res_pre   (res_pre),
  .res_div   (res_div),
  .res_err   (res_err)
);

// File: tb/sim_pwm_divpair_search.sv
module sim_pwm_divpair_search;
  localparam int TGT_W = 32;
  localparam int DIV_W = 16;

  typedef struct packed {
    logic [15:0] pre;
    logic [15:0] dv;
    logic [31:0] err;
    logic [31:0] ncand;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_target = '0;
  logic        done;
  logic [15:0] res_pre, res_div;
  logic [31:0] res_err;

  int total = 0;
  int bad   = 0;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  pwm_divpair_search #(.TGT_W(TGT_W), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_target(req_target), .done(done), .res_pre(res_pre),
    .res_div(res_div), .res_err(res_err)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected result computed from the requirement rules
  function automatic exp_t model(input logic [31:0] t);
    exp_t e;
    longint p, q, r, d;
    e.pre = 16'hFFFF; e.dv = 16'hFFFF; e.err = t; e.ncand = 0;
    p = longint'(t) >> 16;                             // R2
    forever begin
      e.ncand++;
      q = longint'(t) / (p + 1);                        // R3
      r = longint'(t) % (p + 1);
      if (q == 0) break;                                // R4
      d = q - 1;
      if (p > d) break;                                 // R4
      if (d <= 64'hFFFE && r < longint'(e.err)) begin   // R5 R6
        e.pre = 16'(p); e.dv = 16'(d); e.err = 32'(r);
        if (r == 0) break;                              // R7
      end
      if (p == 64'hFFFF) break;                         // R9
      p++;
    end
    return e;
  endfunction

  // monitor: pops the scoreboard on every result pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(res_pre == e.pre, "R3 prescaler", res_pre, e.pre);
        chk(res_div == e.dv,  "R3 divider",   res_div, e.dv);
        chk(res_err == e.err, "R6 error",     res_err, e.err);
      end
    end
  end

  // driver: pushes the expectation, sends, waits for the pulse
  task automatic run_case(input logic [31:0] t, input bit poke_busy);
    exp_t e;
    int lat;
    logic [15:0] hp, hd;
    logic [31:0] he;
    e = model(t);
    sb_q.push_back(e);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_target = t;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      req_valid = 1'b0;
      if (poke_busy && lat == 5) begin
        chk(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
        req_valid = 1'b1;
        req_target = 32'd65536;
      end
      if (poke_busy && lat == 9) req_valid = 1'b0;
    end while (!done);
    chk(lat <= int'(e.ncand) * (TGT_W + 4), "R7 latency bound", lat, int'(e.ncand) * (TGT_W + 4));
    hp = res_pre; hd = res_div; he = res_err;
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    @(negedge clk);
    chk({res_pre, res_div, res_err} == {hp, hd, he}, "R10 result held", res_err, he);
    chk(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1,  "R11 reset ready", req_ready, 1);
    chk(done == 1'b0,       "R11 reset done",  done, 0);
    chk(res_pre == 16'hFFFF && res_div == 16'hFFFF, "R11 reset pair", res_pre, 16'hFFFF);
    chk(res_err == 32'd0,   "R11 reset error", res_err, 0);

    run_case(32'd0, 0);            // R4 R8: quotient zero at once
    run_case(32'd1, 0);            // R7: exact at p=0, d=0
    run_case(32'd2, 0);
    run_case(32'd65535, 0);        // R3: p=0, d=0xFFFE
    run_case(32'd65536, 0);        // R2: starts at p=1, exact
    run_case(32'd196608, 0);       // R2: starts at p=3, exact
    run_case(32'd65537, 1);        // R6 strict; R1 busy poke ignored
    run_case(32'd131071, 0);       // R6: best error 1 at p=1
    run_case(32'd140000, 0);       // R7: exact at second candidate
    run_case(32'd196611, 0);       // R6: several improvements
    run_case(32'hFFFF_FFFF, 0);    // R8 R9: p=0xFFFF is past the mirror
    chk(sb_q.size() == 0, "R10 all results seen", sb_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 190000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule